// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Write Front End

This block is the receive side of a two-wire slave that stores writes into a serial nonvolatile memory. It oversamples the clock and data lines on the system clock and finds START and STOP conditions. It decodes the device select byte, then takes a word address and a stream of data bytes. The data bytes are gathered in a page buffer of 2^OFS_W bytes. Each stored byte sets a bit in a valid mask.

The word address has two parts. The upper bits name the page, which stays fixed for the whole transfer. The lower bits are a byte offset that moves forward by one after each accepted byte and wraps inside the page. The slave drives the acknowledge bit through an open-drain enable. A device mismatch, a read request, a busy write-cycle sequencer or a protected write all withhold the acknowledge.

When a STOP ends a transfer that has at least one complete, acknowledged data byte, the block pulses a commit strobe. The separate write-cycle sequencer then reads the buffer, the mask, the page address and the sector select.

Top module: `tw_eeprom_wr`

## Requirements
- R1: After reset, sda_oe is 0, commit is 0 and byte_valid is all zeros.
- R2: The device byte is acknowledged only when all of these hold: bits 7:4 are 1010, bits 3:2 equal addr_pin[1:0], bit 0 is 0 (write), and seq_busy is low. A type or pin mismatch gets no ACK, and the rest of the transfer then gets no ACK, stores nothing and commits nothing.
- R3: A device byte with bit 0 = 1 (read) gets no ACK and leads to no commit.
- R4: Bit 1 of the device byte appears on sector_sel from the word address onward, so it is valid when commit pulses. 0 selects the memory array and 1 selects the control register space.
- R5: The word address byte is acknowledged. Its bits 7:4 appear on page_addr and its bits 3:0 are the first byte offset.
- R6: Each data byte taken while writing is allowed is acknowledged and stored at the current offset, and its byte_valid bit is set. The offset then moves forward by one and wraps from 15 to 0. For example, 12 bytes sent from offset 10 fill offsets 10..15 and then 0..5, and a 13th byte lands at offset 6.
- R7: When more than 16 data bytes are sent, each later byte overwrites the byte stored earlier at the same offset.
- R8: commit is a one-cycle pulse. It pulses for a STOP that follows at least one data byte and its ACK, where the STOP falls in the first SCL-high of the next byte. A STOP after only the device and word bytes, or one that comes after two or more bits of a data byte, commits nothing and clears byte_valid.
- R9: Writing is allowed only when all of these hold: vp_ok = 1, wel_bit = 1, and at least one of wp_pin and wpen_bit is 0. When writing is not allowed, a data byte gets no ACK, nothing is stored and no commit follows.
- R10: While seq_busy is high when the device byte completes, the slave gives no ACK, even for its own address, and commits nothing.
- R11: A repeated START clears byte_valid and restarts decoding at the device byte.
- R12: sda_oe rises only in the cycle after a synchronized SCL falling edge. It stays low while the master sends data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired level) |
| addr_pin | input | 2 | External device address straps |
| wp_pin | input | 1 | Write-protect pin level |
| wel_bit | input | 1 | Write enable latch bit |
| wpen_bit | input | 1 | Write-protect enable register bit |
| vp_ok | input | 1 | Programming supply present |
| seq_busy | input | 1 | Write-cycle sequencer busy |
| sda_oe | output | 1 | Pull SDA low when 1 |
| page_data | output | 8*2^OFS_W | Page buffer, byte i at bits 8i+7:8i |
| byte_valid | output | 2^OFS_W | One bit per buffered byte |
| page_addr | output | 8-OFS_W | Page part of the word address |
| sector_sel | output | 1 | Sector select from device byte bit 1 |
| commit | output | 1 | One-cycle write commit request |

## Verification
Some rules are checked by assertions on every cycle. The acknowledge may only start after an SCL fall, and the device byte is never acknowledged while the sequencer is busy. A data byte is never acknowledged unless writing is allowed. The valid mask never gains more than one bit per cycle, and commit never pulses with an empty mask. Other behaviour only shows up across whole transfers, so the directed scenarios cover it. These are the device type and pin decode, the sector bit, offset wrap and overwrite, the abort rules for a short or mid-byte STOP, the protection combinations, and the restart on a repeated START.

// File: rtl/eewr_pkg.sv
// Shared types and constants for the two-wire write front end.
package eewr_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WADR,
        ST_DATA,
        ST_SKIP
    } tw_state_t;
endpackage

// File: rtl/tw_line_sync.sv
// Synchronizes SCL/SDA into the clock domain and flags edges and bus
// conditions. Assumes SYNC_STAGES >= 2 and lines idle high.
module tw_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_sh, sda_sh;
    logic         scl_p, sda_p, scl_q;

    // Shift raw lines through the synchronizer and keep one previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[MSB-1:0], scl_in};
            sda_sh <= {sda_sh[MSB-1:0], sda_in};
            scl_p  <= scl_sh[MSB];
            sda_p  <= sda_sh[MSB];
        end
    end

    // Edge and START/STOP detection on the synchronized samples.
    always_comb begin
        scl_q     = scl_sh[MSB];
        sda_q     = sda_sh[MSB];
        scl_rise  = scl_q & ~scl_p;
        scl_fall  = ~scl_q & scl_p;
        start_det = scl_q & scl_p & sda_p & ~sda_q;
        stop_det  = scl_q & scl_p & ~sda_p & sda_q;
    end
endmodule

// File: rtl/tw_page_buf.sv
// Page buffer with per-byte valid mask. One byte write per cycle; clr
// drops all valid bits (data is kept). Assumes clr and we never coincide.
module tw_page_buf #(
    parameter int OFS_W  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          we,
    input  logic [OFS_W-1:0]              wofs,
    input  logic [BYTE_W-1:0]             wdata,
    output logic [(1<<OFS_W)*BYTE_W-1:0]  page_data,
    output logic [(1<<OFS_W)-1:0]         valid
);
    localparam int PAGE_BYTES = 1 << OFS_W;

    logic [BYTE_W-1:0] mem [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        // Store one byte and track whether it holds new data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i]   <= '0;
                valid[i] <= 1'b0;
            end else if (clr) begin
                valid[i] <= 1'b0;
            end else if (we && wofs == OFS_W'(i)) begin
                mem[i]   <= wdata;
                valid[i] <= 1'b1;
            end
        end
        assign page_data[i*BYTE_W +: BYTE_W] = mem[i];
    end

    // R6: the mask gains at most one byte per cycle
    a_r6_one_byte_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($countones(valid) <= $countones($past(valid)) + 1));
endmodule

// File: rtl/tw_wr_ctrl.sv
// Byte framing, address decode, ACK generation, offset counter and commit
// decision. Bits are sampled on SCL rise; ACK is driven from the fall after
// the 8th bit to the next fall. Assumes edge flags from tw_line_sync.
module tw_wr_ctrl
    import eewr_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sda_q,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_det,
    input  logic                    stop_det,
    input  logic [1:0]              addr_pin,
    input  logic                    seq_busy,
    input  logic                    wr_allow,
    output logic                    sda_oe,
    output logic                    buf_clr,
    output logic                    buf_we,
    output logic [OFS_W-1:0]        buf_ofs,
    output logic [BYTE_W-1:0]       buf_wdata,
    output logic [BYTE_W-OFS_W-1:0] page_addr,
    output logic                    sector_sel,
    output logic                    commit
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    tw_state_t         st;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh;
    logic [OFS_W-1:0]  ofs;
    logic              in_ack, data_ack, got_data;

    // Main sequencing: framing, decode, ACK slot and commit/abort on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  bitcnt <= '0;  sh <= '0;  ofs <= '0;
            in_ack <= 1'b0;  data_ack <= 1'b0;  got_data <= 1'b0;
            sda_oe <= 1'b0;  buf_clr <= 1'b0;  buf_we <= 1'b0;
            buf_ofs <= '0;  buf_wdata <= '0;  page_addr <= '0;
            sector_sel <= 1'b0;  commit <= 1'b0;
        end else begin
            buf_clr <= 1'b0;
            buf_we  <= 1'b0;
            commit  <= 1'b0;
            if (start_det) begin
                st <= ST_ADDR;  bitcnt <= '0;  in_ack <= 1'b0;
                data_ack <= 1'b0;  got_data <= 1'b0;
                sda_oe <= 1'b0;  buf_clr <= 1'b1;
            end else if (stop_det) begin
                if (st == ST_DATA && got_data && !in_ack && bitcnt <= CNT_W'(1))
                    commit <= 1'b1;
                else if (st != ST_IDLE)
                    buf_clr <= 1'b1;
                st <= ST_IDLE;  bitcnt <= '0;  in_ack <= 1'b0;
                data_ack <= 1'b0;  sda_oe <= 1'b0;
            end else if (st == ST_ADDR || st == ST_WADR || st == ST_DATA) begin
                if (scl_rise && !in_ack) begin
                    sh     <= {sh[BYTE_W-2:0], sda_q};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (scl_fall) begin
                    if (in_ack) begin
                        in_ack   <= 1'b0;
                        sda_oe   <= 1'b0;
                        data_ack <= 1'b0;
                        if (data_ack) got_data <= 1'b1;
                    end else if (bitcnt == CNT_W'(BYTE_W)) begin
                        bitcnt <= '0;
                        in_ack <= 1'b1;
                        case (st)
                            ST_ADDR: begin
                                if (sh[7:4] == DEV_TYPE && sh[3:2] == addr_pin
                                    && !sh[0] && !seq_busy) begin
                                    sda_oe     <= 1'b1;
                                    sector_sel <= sh[1];
                                    st         <= ST_WADR;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                            ST_WADR: begin
                                sda_oe    <= 1'b1;
                                page_addr <= sh[BYTE_W-1:OFS_W];
                                ofs       <= sh[OFS_W-1:0];
                                st        <= ST_DATA;
                            end
                            default: begin
                                if (wr_allow) begin
                                    sda_oe    <= 1'b1;
                                    buf_we    <= 1'b1;
                                    buf_ofs   <= ofs;
                                    buf_wdata <= sh;
                                    ofs       <= ofs + 1'b1;
                                    data_ack  <= 1'b1;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                        endcase
                    end
                end
            end
        end
    end

    // R12: the ACK only begins right after an SCL fall
    a_r12_ack_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    // R10: the device byte is never acknowledged while the sequencer is busy
    a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && $past(st) == ST_ADDR) |-> !$past(seq_busy));
    // R9: a data byte is acknowledged only when writing is allowed
    a_r9_protect_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && $past(st) == ST_DATA) |-> $past(wr_allow));
endmodule

// File: rtl/tw_eeprom_wr.sv
// Top of the two-wire write front end: line synchronizer, control FSM and
// page buffer. The write-allow term combines supply, latch and protection.
module tw_eeprom_wr
    import eewr_pkg::*;
#(
    parameter int OFS_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_in,
    input  logic                         sda_in,
    input  logic [1:0]                   addr_pin,
    input  logic                         wp_pin,
    input  logic                         wel_bit,
    input  logic                         wpen_bit,
    input  logic                         vp_ok,
    input  logic                         seq_busy,
    output logic                         sda_oe,
    output logic [(1<<OFS_W)*8-1:0]      page_data,
    output logic [(1<<OFS_W)-1:0]        byte_valid,
    output logic [8-OFS_W-1:0]           page_addr,
    output logic                         sector_sel,
    output logic                         commit
);
    logic sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic buf_clr, buf_we, wr_allow;
    logic [OFS_W-1:0]  buf_ofs;
    logic [BYTE_W-1:0] buf_wdata;

    assign wr_allow = vp_ok & wel_bit & (~wp_pin | ~wpen_bit);

    tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tw_wr_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_pin(addr_pin), .seq_busy(seq_busy), .wr_allow(wr_allow),
        .sda_oe(sda_oe), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_ofs(buf_ofs), .buf_wdata(buf_wdata), .page_addr(page_addr),
        .sector_sel(sector_sel), .commit(commit)
    );

    tw_page_buf #(.OFS_W(OFS_W), .BYTE_W(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .wofs(buf_ofs), .wdata(buf_wdata), .page_data(page_data),
        .valid(byte_valid)
    );

    // R8: a commit never goes out with an empty page buffer
    a_r8_commit_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (byte_valid != '0));
endmodule

// File: tb/tw_eeprom_wr_test.sv
// Directed bench: a bus master model drives SCL/SDA over an open-drain line.
module tw_eeprom_wr_test;
    localparam int TQ = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_pin = 2'b01;
    logic wp_pin = 1'b0, wel_bit = 1'b1, wpen_bit = 1'b1, vp_ok = 1'b1;
    logic seq_busy = 1'b0;
    logic sda_oe, sector_sel, commit;
    logic [127:0] page_data;
    logic [15:0]  byte_valid;
    logic [3:0]   page_addr;
    wire  sda_line = sda_m & ~sda_oe;

    int nchk = 0, nfail = 0, ncommit = 0;

    always #2 clk = ~clk;

    tw_eeprom_wr uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_pin(addr_pin), .wp_pin(wp_pin), .wel_bit(wel_bit),
        .wpen_bit(wpen_bit), .vp_ok(vp_ok), .seq_busy(seq_busy),
        .sda_oe(sda_oe), .page_data(page_data), .byte_valid(byte_valid),
        .page_addr(page_addr), .sector_sel(sector_sel), .commit(commit)
    );

    always @(posedge clk) if (rst_n && commit) ncommit <= ncommit + 1;

    task automatic check(input int act, input int exp, input string tag);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (TQ) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait(); qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait(); scl_m = 1'b1; qwait();
        check(int'(sda_oe), 0, "R12 oe low during data bit");
        qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        ack = ~sda_line;
        qwait(); scl_m = 1'b0; qwait();
    endtask

    function automatic int pbyte(input int i);
        return int'(page_data[i*8 +: 8]);
    endfunction

    task automatic t_reset();
        check(int'(sda_oe), 0, "R1 sda_oe");
        check(ncommit, 0, "R1 commit");
        check(int'(byte_valid), 0, "R1 byte_valid");
    endtask

    task automatic t_byte_write();
        logic a; int c0 = ncommit;
        bus_start();
        send_byte(8'hA4, a); check(int'(a), 1, "R2 address ack");
        send_byte(8'h35, a); check(int'(a), 1, "R5 word address ack");
        send_byte(8'h5A, a); check(int'(a), 1, "R6 data ack");
        bus_stop();
        check(ncommit - c0, 1, "R8 commit after byte");
        check(int'(page_addr), 3, "R5 page_addr");
        check(int'(byte_valid), 16'h0020, "R6 valid at offset 5");
        check(pbyte(5), 8'h5A, "R6 data at offset 5");
        check(int'(sector_sel), 0, "R4 sector array");
    endtask

    task automatic t_wrap();
        logic a; int c0 = ncommit;
        bus_start();
        send_byte(8'hA6, a); check(int'(a), 1, "R2 ack sector 1");
        send_byte(8'h7A, a);
        for (int i = 0; i < 13; i++) send_byte(8'(8'h10 + i), a);
        bus_stop();
        check(ncommit - c0, 1, "R8 commit after wrap");
        check(int'(sector_sel), 1, "R4 sector control");
        check(int'(page_addr), 7, "R5 page_addr 7");
        check(int'(byte_valid), 16'hFC7F, "R6 wrap mask");
        check(pbyte(10), 8'h10, "R6 first at 10");
        check(pbyte(15), 8'h15, "R6 at 15");
        check(pbyte(0), 8'h16, "R6 wrapped to 0");
        check(pbyte(6), 8'h1C, "R6 13th byte at 6");
    endtask

    task automatic t_overwrite();
        logic a;
        bus_start();
        send_byte(8'hA4, a); send_byte(8'h00, a);
        for (int i = 0; i < 18; i++) send_byte(8'(i), a);
        bus_stop();
        check(int'(byte_valid), 16'hFFFF, "R7 full mask");
        check(pbyte(0), 16, "R7 offset 0 overwritten");
        check(pbyte(1), 17, "R7 offset 1 overwritten");
        check(pbyte(2), 2, "R7 offset 2 kept");
    endtask

    task automatic t_mismatch();
        logic a; int c0 = ncommit;
        bus_start();
        send_byte(8'hB4, a); check(int'(a), 0, "R2 type mismatch nack");
        send_byte(8'h00, a); check(int'(a), 0, "R2 ignored word");
        send_byte(8'h11, a); check(int'(a), 0, "R2 ignored data");
        bus_stop();
        bus_start();
        send_byte(8'hA0, a); check(int'(a), 0, "R2 pin mismatch nack");
        bus_stop();
        check(ncommit - c0, 0, "R2 no commit on mismatch");
        check(int'(byte_valid), 0, "R2 nothing stored");
    endtask

    task automatic t_read();
        logic a; int c0 = ncommit;
        bus_start();
        send_byte(8'hA5, a); check(int'(a), 0, "R3 read nack");
        bus_stop();
        check(ncommit - c0, 0, "R3 no commit");
    endtask

    task automatic t_short_stop();
        logic a; int c0 = ncommit;
        bus_start();
        send_byte(8'hA4, a); send_byte(8'h20, a);
        bus_stop();
        check(ncommit - c0, 0, "R8 no commit without data");
        bus_start();
        send_byte(8'hA4, a); send_byte(8'h20, a); send_byte(8'h99, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check(ncommit - c0, 0, "R8 no commit mid-byte stop");
        check(int'(byte_valid), 0, "R8 mask cleared on abort");
    endtask

    task automatic prot_try(input logic wp, input logic we, input logic vp,
                            input int exp_ack, input string tag);
        logic a; int c0 = ncommit;
        wp_pin = wp; wel_bit = we; vp_ok = vp; wpen_bit = 1'b1;
        bus_start();
        send_byte(8'hA4, a); send_byte(8'h10, a);
        send_byte(8'h42, a); check(int'(a), exp_ack, tag);
        bus_stop();
        check(ncommit - c0, exp_ack, tag);
        check(int'(byte_valid), exp_ack, tag);
    endtask

    task automatic t_protect();
        prot_try(1'b1, 1'b1, 1'b1, 0, "R9 wp and wpen high");
        prot_try(1'b0, 1'b0, 1'b1, 0, "R9 wel low");
        prot_try(1'b0, 1'b1, 1'b0, 0, "R9 supply missing");
        wpen_bit = 1'b0; wp_pin = 1'b1; wel_bit = 1'b1; vp_ok = 1'b1;
        begin
            logic a; int c0 = ncommit;
            bus_start();
            send_byte(8'hA4, a); send_byte(8'h10, a);
            send_byte(8'h42, a); check(int'(a), 1, "R9 wpen low allows");
            bus_stop();
            check(ncommit - c0, 1, "R9 commit wpen low");
        end
        wp_pin = 1'b0; wpen_bit = 1'b1;
    endtask

    task automatic t_busy();
        logic a; int c0 = ncommit;
        seq_busy = 1'b1;
        bus_start();
        send_byte(8'hA4, a); check(int'(a), 0, "R10 busy nack");
        send_byte(8'h00, a); send_byte(8'h55, a);
        check(int'(a), 0, "R10 busy data nack");
        bus_stop();
        seq_busy = 1'b0;
        check(ncommit - c0, 0, "R10 no commit when busy");
    endtask

    task automatic t_restart();
        logic a; int c0 = ncommit;
        bus_start();
        send_byte(8'hA4, a); send_byte(8'h12, a); send_byte(8'h33, a);
        bus_start();
        send_byte(8'hA4, a); check(int'(a), 1, "R11 ack after restart");
        send_byte(8'h40, a); send_byte(8'h77, a);
        bus_stop();
        check(ncommit - c0, 1, "R11 one commit");
        check(int'(page_addr), 4, "R11 new page");
        check(int'(byte_valid), 16'h0001, "R11 old byte dropped");
        check(pbyte(0), 8'h77, "R11 new data");
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        qwait();
        t_reset();
        t_byte_write();
        t_wrap();
        t_overwrite();
        t_mismatch();
        t_read();
        t_short_stop();
        t_protect();
        t_busy();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule